// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block sequences the control store of a tiny four-instruction CPU. A 4-bit control address register (CAR) points into an internal microcode ROM. Sixteen locations are decoded and nine of them hold states. Each microword carries three fields: a source-select bit, a 4-bit absolute jump target, and a one-hot control field that names the active state. Each cycle a 2-to-1 multiplexer loads the register with one of two values. The first is the jump target. The second is an opcode-derived entry address, built by wiring alone from two instruction-register bits.

The selection never depends on a status flag. The last fetch state always takes the opcode entry. Every other word always takes its own jump target. Each execute routine ends with a jump back to the first fetch state. The datapath reads the control field directly, and the CAR value is visible for observation.

Reset is asserted asynchronously and active-low. Its release is synchronised inside the block by a two-stage chain, so the sequencer starts stepping on the third rising edge after the release.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, `car` reads 0 without waiting for a clock edge. After `rst_n` rises, `car` stays 0 across two rising edges and first advances on the third.
- R2: The fetch states chain as address 0 → 1 → 2, one step per rising edge.
- R3: At address 2 the next address is {1, ir_op[1:0], 0}. Opcode 00 enters at 8, 01 at 10, 10 at 12 and 11 at 14.
- R4: The execute chains are 8 → 9 → 0, 10 → 11 → 0, 12 → 0 and 14 → 0.
- R5: `ir_op` has no effect on the next address in any state except address 2.
- R6: `ctrl` is one-hot on the used addresses, with the bit order 0→bit0, 1→bit1, 2→bit2, 8→bit3, 9→bit4, 10→bit5, 11→bit6, 12→bit7, 14→bit8. It is all zeros on unused addresses, which jump to 0.
- R7: `map_sel` is 1 exactly when `car` is 2, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ir_op | input | 2 | Instruction-register opcode bits |
| car | output | 4 | Current control address |
| map_sel | output | 1 | Select bit of the current microword (1 = opcode entry) |
| ctrl | output | 9 | One-hot control field of the current microword |

## Verification
The bench runs every opcode through a complete fetch-execute pass. It holds the opposite opcode on `ir_op` in every cycle except the one where the mapping is taken. A design that sampled the opcode in the wrong state, or wired the mapping bits in a shifted or swapped order, would enter the wrong routine. A design with a wrong chain link or a missing return would leave the expected address sequence, and a misplaced control bit would show up as a one-hot mismatch. Reset is also asserted in the middle of an execute routine. This catches a CAR that clears only on a clock edge, and a release that starts stepping one cycle too early or too late.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int AW    = 4;
  localparam int OPW   = 2;
  localparam int NCTRL = 9;

  localparam logic [AW-1:0] A_F1  = 4'd0;
  localparam logic [AW-1:0] A_F2  = 4'd1;
  localparam logic [AW-1:0] A_F3  = 4'd2;
  localparam logic [AW-1:0] A_AD1 = 4'd8;
  localparam logic [AW-1:0] A_AD2 = 4'd9;
  localparam logic [AW-1:0] A_AN1 = 4'd10;
  localparam logic [AW-1:0] A_AN2 = 4'd11;
  localparam logic [AW-1:0] A_JP1 = 4'd12;
  localparam logic [AW-1:0] A_IN1 = 4'd14;

  typedef struct packed {
    logic             sel_map;
    logic [AW-1:0]    jump;
    logic [NCTRL-1:0] ctrl;
  } uword_t;
endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
(
  input  logic [AW-1:0] addr,
  output uword_t        word
);
  function automatic uword_t mk(logic s, logic [AW-1:0] j, int bit_idx);
    uword_t w;
    w.sel_map = s;
    w.jump    = j;
    w.ctrl    = '0;
    if (bit_idx >= 0) w.ctrl[bit_idx] = 1'b1;
    return w;
  endfunction

  always_comb begin
    unique case (addr)
      A_F1:    word = mk(1'b0, A_F2, 0);
      A_F2:    word = mk(1'b0, A_F3, 1);
      A_F3:    word = mk(1'b1, A_F1, 2);
      A_AD1:   word = mk(1'b0, A_AD2, 3);
      A_AD2:   word = mk(1'b0, A_F1, 4);
      A_AN1:   word = mk(1'b0, A_AN2, 5);
      A_AN2:   word = mk(1'b0, A_F1, 6);
      A_JP1:   word = mk(1'b0, A_F1, 7);
      A_IN1:   word = mk(1'b0, A_F1, 8);
      default: word = mk(1'b0, A_F1, -1);
    endcase
  end

  always_comb begin
    assert ($onehot0(word.ctrl)) else $error("p_ctrl_onehot_r6");
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
(
  input  uword_t         word,
  input  logic [OPW-1:0] ir_op,
  output logic [AW-1:0]  nxt
);
  logic [AW-1:0] map_addr;

  // entry address formed by wiring only
  assign map_addr = {1'b1, ir_op, 1'b0};

  always_comb begin
    nxt = word.sel_map ? map_addr : word.jump;
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPW-1:0]   ir_op,
  output logic [AW-1:0]    car,
  output logic             map_sel,
  output logic [NCTRL-1:0] ctrl
);
  logic          rst_sync_n;
  logic [AW-1:0] car_q;
  logic [AW-1:0] car_d;
  logic          car_en;
  uword_t        word;

  useq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  useq_rom u_rom (.addr(car_q), .word(word));

  useq_next_addr u_nxt (.word(word), .ir_op(ir_op), .nxt(car_d));

  assign car_en = 1'b1;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  car_q <= A_F1;
    else if (car_en)  car_q <= car_d;
  end

  assign car     = car_q;
  assign map_sel = word.sel_map;
  assign ctrl    = word.ctrl;

  p_fetch_chain_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (car_q == A_F1) |=> (car_q == A_F2));
  p_map_entry_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (car_q == A_F3) |=> (car_q == {1'b1, $past(ir_op), 1'b0}));
  p_exec_return_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (car_q == A_AD2 || car_q == A_AN2 || car_q == A_JP1 || car_q == A_IN1)
    |=> (car_q == A_F1));
  p_sel_only_f3_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    map_sel == (car_q == A_F3));
  p_ctrl_hot_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(ctrl) == 1);
endmodule

// File: tb/test_useq_ctrl.sv
`timescale 1ns/1ps
module test_useq_ctrl;
  logic       clk;
  logic       rst_n;
  logic [1:0] ir_op;
  logic [3:0] car;
  logic       map_sel;
  logic [8:0] ctrl;

  int checks   = 0;
  int failures = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  useq_ctrl i_useq_ctrl (
    .clk(clk), .rst_n(rst_n), .ir_op(ir_op),
    .car(car), .map_sel(map_sel), .ctrl(ctrl)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // R6 bit order
  function automatic logic [8:0] exp_ctrl(logic [3:0] a);
    case (a)
      4'd0:  return 9'b000000001;
      4'd1:  return 9'b000000010;
      4'd2:  return 9'b000000100;
      4'd8:  return 9'b000001000;
      4'd9:  return 9'b000010000;
      4'd10: return 9'b000100000;
      4'd11: return 9'b001000000;
      4'd12: return 9'b010000000;
      4'd14: return 9'b100000000;
      default: return 9'b0;
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: set inputs before the edge, queue the CAR value expected after it
  task automatic step(logic [1:0] op, logic rst, logic [3:0] exp, string tag);
    @(negedge clk);
    ir_op = op;
    rst_n = rst;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic run_op(logic [1:0] op);
    logic [3:0] entry;
    entry = {1'b1, op, 1'b0};
    step(~op, 1'b1, 4'd1, "R2");
    step(~op, 1'b1, 4'd2, "R2");
    step(op,  1'b1, entry, "R3");
    if (op == 2'b00 || op == 2'b01) begin
      step(~op, 1'b1, entry + 4'd1, "R4 R5");
      step(~op, 1'b1, 4'd0, "R4");
    end else begin
      step(~op, 1'b1, 4'd0, "R4 R5");
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {12'd0, car}, {12'd0, e});
        chk({t, " R6"}, {7'd0, ctrl}, {7'd0, exp_ctrl(e)});
        chk({t, " R7"}, {15'd0, map_sel}, {15'd0, (e == 4'd2)});
      end
    end
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ir_op = 2'b00;
    step(2'b00, 1'b0, 4'd0, "R1");
    step(2'b00, 1'b0, 4'd0, "R1");
    // release: two held edges, then advance (R1)
    step(2'b11, 1'b1, 4'd0, "R1");
    step(2'b11, 1'b1, 4'd0, "R1");
    run_op(2'b00);
    run_op(2'b01);
    run_op(2'b10);
    run_op(2'b11);
    run_op(2'b01);
    // mid-routine asynchronous reset (R1)
    step(2'b10, 1'b1, 4'd1, "R2");
    step(2'b10, 1'b1, 4'd2, "R2");
    step(2'b00, 1'b1, 4'd8, "R3");
    @(negedge clk);
    wait (exp_q.size() == 0);
    @(negedge clk);
    chk("R1 pre", {12'd0, car}, 16'd9);
    rst_n = 1'b0;
    #1;
    chk("R1 async", {12'd0, car}, 16'd0);
    step(2'b00, 1'b0, 4'd0, "R1");
    step(2'b00, 1'b1, 4'd0, "R1");
    step(2'b00, 1'b1, 4'd0, "R1");
    run_op(2'b10);
    run_op(2'b00);
    @(negedge clk);
    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule